// File: doc/BRIEF.md
# Privilege-Checked Flag Clear Unit

This block carries out three single-byte flag-clearing instructions against a registered processor flags word. It can clear the carry flag, clear the direction flag, or clear the interrupt flag. Each instruction arrives as an opcode byte with a valid strobe. The strobe comes with a lock-prefix indicator, the current mode bits and the two privilege levels. The block updates its flags register on the next clock edge. If the instruction is not permitted, it raises a one-cycle fault pulse instead.

Clearing the carry or direction flag is unconditional. Clearing the interrupt flag goes through a privilege decision that depends on the mode. The outcome is one of three: the real interrupt flag is cleared, a separate virtual interrupt flag is cleared and the real one is left alone, or a general-protection fault is raised. Any of the three instructions carrying a lock prefix raises an invalid-opcode fault.

A parallel load port lets the surrounding logic, or a bench, preset the whole flags word.

Top module: `flag_clear_unit`

## Requirements
- R1: While the synchronous, active-high `rst` is asserted, `flags_q` is all zero after each rising edge, and neither fault output is asserted.
- R2: A valid opcode 0xF8 without lock clears the carry flag (bit 0) at the next rising edge. The other flag bits are unchanged. The flag bit layout is: bit0 carry, bit1 parity, bit2 aux, bit3 zero, bit4 sign, bit5 direction, bit6 overflow, bit7 interrupt, bit8 virtual interrupt.
- R3: A valid opcode 0xFC without lock clears the direction flag (bit 5) at the next rising edge. The other flag bits are unchanged.
- R4: A valid opcode 0xF8, 0xFC or 0xFA with `lock_pfx` high makes `ud_fault` high for the one cycle after the edge. No flag is changed, and no general-protection fault is raised.
- R5: A valid opcode other than 0xF8, 0xFC and 0xFA, with or without lock, changes no flag and raises no fault. Cycles without `op_valid` likewise hold the flags.
- R6: A valid opcode 0xFA without lock and with `pe` low clears the interrupt flag (bit 7), whatever the other mode bits are.
- R7: With `pe` high and `vm` low, a valid 0xFA without lock behaves as follows. If `iopl` ≥ `cpl` (2-bit unsigned), it clears bit 7. Otherwise, if `cpl` is 3 and `pvi` is high, it clears bit 8 and leaves bit 7 alone. In any other case it raises `gp_fault`.
- R8: With `pe` and `vm` high, a valid 0xFA without lock behaves as follows. If `iopl` is 3, it clears bit 7. Otherwise, if `vme` is high, it clears bit 8. Otherwise it raises `gp_fault`.
- R9: A faulting instruction changes no flag. Each fault output is high only in the cycle after the strobe that caused it, and the two fault outputs are never high together.
- R10: With `load_en` high, `flags_q` takes `load_flags` at the next rising edge. This takes priority over any flag update from an instruction in the same cycle, but fault pulses are still produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction strobe |
| opcode | input | 8 | Decoded opcode byte |
| lock_pfx | input | 1 | Lock prefix present |
| pe | input | 1 | Protected-mode enable |
| vm | input | 1 | Virtual-8086 mode |
| vme | input | 1 | Virtual-mode extensions enable |
| pvi | input | 1 | Protected-mode virtual interrupts enable |
| cpl | input | 2 | Current privilege level |
| iopl | input | 2 | I/O privilege level |
| load_en | input | 1 | Parallel load strobe for the flags word |
| load_flags | input | 9 | Value to load into the flags word |
| flags_q | output | 9 | Registered flags word |
| gp_fault | output | 1 | General-protection fault pulse |
| ud_fault | output | 1 | Invalid-opcode fault pulse |

## Verification
The properties take for granted that the inputs are stable around each rising edge. They also assume that `load_en` is low in any cycle where a flag-update property applies; most of them carry that condition in their antecedent. The bench drives every input on the falling edge. It keeps loads and instructions in separate cycles, except for one deliberate overlap case that exercises the load priority. All 256 combinations of mode bits and privilege levels are swept for the interrupt-clear instruction, each starting from a freshly loaded all-ones word.

// File: rtl/flag_clear_pkg.sv
package flag_clear_pkg;
  localparam int FLAG_W  = 9;
  localparam int B_CF    = 0;
  localparam int B_PF    = 1;
  localparam int B_AF    = 2;
  localparam int B_ZF    = 3;
  localparam int B_SF    = 4;
  localparam int B_DF    = 5;
  localparam int B_OF    = 6;
  localparam int B_IF    = 7;
  localparam int B_VIF   = 8;

  typedef enum logic [1:0] {
    OPK_NONE = 2'd0,
    OPK_CLC  = 2'd1,
    OPK_CLD  = 2'd2,
    OPK_CLI  = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    ACT_CLR_IF  = 2'd0,
    ACT_CLR_VIF = 2'd1,
    ACT_GP      = 2'd2
  } cli_act_e;

  function automatic logic [FLAG_W-1:0] bit_mask(input int idx);
    logic [FLAG_W-1:0] m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/fcu_decode.sv
module fcu_decode
  import flag_clear_pkg::*;
#(
  parameter logic [7:0] OPC_CLC = 8'hF8,
  parameter logic [7:0] OPC_CLD = 8'hFC,
  parameter logic [7:0] OPC_CLI = 8'hFA
) (
  input  logic       valid,
  input  logic [7:0] opcode,
  input  logic       lock_pfx,
  output op_kind_e   kind,
  output logic       ud_evt
);
  always_comb begin
    kind = OPK_NONE;
    if (valid) begin
      if (opcode == OPC_CLC)      kind = OPK_CLC;
      else if (opcode == OPC_CLD) kind = OPK_CLD;
      else if (opcode == OPC_CLI) kind = OPK_CLI;
    end
  end

  assign ud_evt = (kind != OPK_NONE) && lock_pfx;
endmodule

// File: rtl/fcu_priv.sv
module fcu_priv
  import flag_clear_pkg::*;
#(
  parameter int PL_W = 2
) (
  input  logic            pe,
  input  logic            vm,
  input  logic            vme,
  input  logic            pvi,
  input  logic [PL_W-1:0] cpl,
  input  logic [PL_W-1:0] iopl,
  output cli_act_e        act
);
  localparam logic [PL_W-1:0] PL_LEAST = '1;

  function automatic cli_act_e decide(
    input logic pe_i, input logic vm_i, input logic vme_i, input logic pvi_i,
    input logic [PL_W-1:0] cpl_i, input logic [PL_W-1:0] iopl_i);
    cli_act_e r;
    if (!pe_i) begin
      r = ACT_CLR_IF;
    end else if (!vm_i) begin
      if (iopl_i >= cpl_i)                      r = ACT_CLR_IF;
      else if ((cpl_i == PL_LEAST) && pvi_i)    r = ACT_CLR_VIF;
      else                                      r = ACT_GP;
    end else begin
      if (iopl_i == PL_LEAST)                   r = ACT_CLR_IF;
      else if (vme_i)                           r = ACT_CLR_VIF;
      else                                      r = ACT_GP;
    end
    return r;
  endfunction

  assign act = decide(pe, vm, vme, pvi, cpl, iopl);
endmodule

// File: rtl/fcu_flags_reg.sv
module fcu_flags_reg
  import flag_clear_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [FLAG_W-1:0] load_val,
  input  logic [FLAG_W-1:0] clr_mask,
  output logic [FLAG_W-1:0] q
);
  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)              q[i] <= 1'b0;
      else if (load_en)     q[i] <= load_val[i];
      else if (clr_mask[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/flag_clear_unit.sv
module flag_clear_unit
  import flag_clear_pkg::*;
#(
  parameter int         PL_W    = 2,
  parameter logic [7:0] OPC_CLC = 8'hF8,
  parameter logic [7:0] OPC_CLD = 8'hFC,
  parameter logic [7:0] OPC_CLI = 8'hFA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [7:0]        opcode,
  input  logic              lock_pfx,
  input  logic              pe,
  input  logic              vm,
  input  logic              vme,
  input  logic              pvi,
  input  logic [PL_W-1:0]   cpl,
  input  logic [PL_W-1:0]   iopl,
  input  logic              load_en,
  input  logic [FLAG_W-1:0] load_flags,
  output logic [FLAG_W-1:0] flags_q,
  output logic              gp_fault,
  output logic              ud_fault
);
  op_kind_e          kind;
  cli_act_e          act;
  logic              ud_evt;
  logic              gp_evt;
  logic [FLAG_W-1:0] clr_mask;

  fcu_decode #(.OPC_CLC(OPC_CLC), .OPC_CLD(OPC_CLD), .OPC_CLI(OPC_CLI)) u_dec (
    .valid(op_valid), .opcode(opcode), .lock_pfx(lock_pfx),
    .kind(kind), .ud_evt(ud_evt)
  );

  fcu_priv #(.PL_W(PL_W)) u_priv (
    .pe(pe), .vm(vm), .vme(vme), .pvi(pvi), .cpl(cpl), .iopl(iopl), .act(act)
  );

  assign gp_evt = (kind == OPK_CLI) && !lock_pfx && (act == ACT_GP);

  always_comb begin
    clr_mask = '0;
    if (!ud_evt) begin
      unique case (kind)
        OPK_CLC: clr_mask = bit_mask(B_CF);
        OPK_CLD: clr_mask = bit_mask(B_DF);
        OPK_CLI: begin
          if (act == ACT_CLR_IF)       clr_mask = bit_mask(B_IF);
          else if (act == ACT_CLR_VIF) clr_mask = bit_mask(B_VIF);
        end
        default: clr_mask = '0;
      endcase
    end
  end

  fcu_flags_reg u_reg (
    .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_flags),
    .clr_mask(clr_mask), .q(flags_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gp_fault <= 1'b0;
      ud_fault <= 1'b0;
    end else begin
      gp_fault <= gp_evt;
      ud_fault <= ud_evt;
    end
  end
endmodule

// File: rtl/fcu_checker.sv
module fcu_checker
  import flag_clear_pkg::*;
#(
  parameter int         PL_W    = 2,
  parameter logic [7:0] OPC_CLC = 8'hF8,
  parameter logic [7:0] OPC_CLD = 8'hFC,
  parameter logic [7:0] OPC_CLI = 8'hFA
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [7:0]        opcode,
  input logic              lock_pfx,
  input logic              pe,
  input logic              vm,
  input logic              vme,
  input logic              pvi,
  input logic [PL_W-1:0]   cpl,
  input logic [PL_W-1:0]   iopl,
  input logic              load_en,
  input logic [FLAG_W-1:0] load_flags,
  input logic [FLAG_W-1:0] flags_q,
  input logic              gp_fault,
  input logic              ud_fault,
  input logic              gp_evt,
  input logic              ud_evt
);
  localparam logic [PL_W-1:0] TOP_PL = '1;
  localparam logic [FLAG_W-1:0] CF_M  = FLAG_W'(1) << B_CF;
  localparam logic [FLAG_W-1:0] DF_M  = FLAG_W'(1) << B_DF;

  wire live = op_valid && !lock_pfx && !load_en;

  a_r2_clc_only_cf: assert property (@(posedge clk) disable iff (rst)
    (live && opcode == OPC_CLC) |=> flags_q == ($past(flags_q) & ~CF_M));

  a_r3_cld_only_df: assert property (@(posedge clk) disable iff (rst)
    (live && opcode == OPC_CLD) |=> flags_q == ($past(flags_q) & ~DF_M));

  a_r4_lock_keeps_flags: assert property (@(posedge clk) disable iff (rst)
    (op_valid && lock_pfx && !load_en &&
     (opcode == OPC_CLC || opcode == OPC_CLD || opcode == OPC_CLI))
    |=> ud_fault && !gp_fault && $stable(flags_q));

  a_r5_other_opcode_inert: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !load_en && opcode != OPC_CLC && opcode != OPC_CLD && opcode != OPC_CLI)
    |=> $stable(flags_q) && !gp_fault && !ud_fault);

  a_r7_vif_path: assert property (@(posedge clk) disable iff (rst)
    (live && opcode == OPC_CLI && pe && !vm && iopl < cpl && cpl == TOP_PL && pvi)
    |=> !flags_q[B_VIF] && flags_q[B_IF] == $past(flags_q[B_IF]) && !gp_fault);

  a_r8_v86_gp: assert property (@(posedge clk) disable iff (rst)
    (live && opcode == OPC_CLI && pe && vm && iopl != TOP_PL && !vme)
    |=> gp_fault && $stable(flags_q));

  a_r9_faults_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(gp_fault && ud_fault));

  a_r9_gp_has_cause: assert property (@(posedge clk) disable iff (rst)
    gp_fault |-> $past(op_valid));

  a_r9_events_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(gp_evt && ud_evt));

  a_r10_load_wins: assert property (@(posedge clk) disable iff (rst)
    load_en |=> flags_q == $past(load_flags));
endmodule

bind flag_clear_unit fcu_checker #(
  .PL_W(PL_W), .OPC_CLC(OPC_CLC), .OPC_CLD(OPC_CLD), .OPC_CLI(OPC_CLI)
) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .opcode(opcode), .lock_pfx(lock_pfx),
  .pe(pe), .vm(vm), .vme(vme), .pvi(pvi), .cpl(cpl), .iopl(iopl),
  .load_en(load_en), .load_flags(load_flags), .flags_q(flags_q),
  .gp_fault(gp_fault), .ud_fault(ud_fault), .gp_evt(gp_evt), .ud_evt(ud_evt)
);

// File: tb/tb_flag_clear_unit.sv
module tb_flag_clear_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic       lock_pfx = 1'b0;
  logic       pe = 1'b0, vm = 1'b0, vme = 1'b0, pvi = 1'b0;
  logic [1:0] cpl = 2'd0, iopl = 2'd0;
  logic       load_en = 1'b0;
  logic [8:0] load_flags = 9'h0;
  logic [8:0] flags_q;
  logic       gp_fault, ud_fault;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flag_clear_unit dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .opcode(opcode), .lock_pfx(lock_pfx),
    .pe(pe), .vm(vm), .vme(vme), .pvi(pvi), .cpl(cpl), .iopl(iopl),
    .load_en(load_en), .load_flags(load_flags), .flags_q(flags_q),
    .gp_fault(gp_fault), .ud_fault(ud_fault)
  );

  // Behavioural reference: integers and plain decisions.
  int    m_flags = 0;
  bit    m_gp = 0, m_ud = 0;
  string m_tag = "R1";

  always @(posedge clk) begin
    int nf;
    m_gp = 0; m_ud = 0;
    if (rst) begin
      m_flags = 0; m_tag = "R1";
    end else begin
      nf = m_flags; m_tag = "R5";
      if (op_valid && (opcode == 8'hF8 || opcode == 8'hFC || opcode == 8'hFA)) begin
        if (lock_pfx) begin
          m_ud = 1; m_tag = "R4";
        end else if (opcode == 8'hF8) begin
          nf = nf & ~(1 << 0); m_tag = "R2";
        end else if (opcode == 8'hFC) begin
          nf = nf & ~(1 << 5); m_tag = "R3";
        end else if (pe == 0) begin
          nf = nf & ~(1 << 7); m_tag = "R6";
        end else if (vm == 0) begin
          m_tag = "R7";
          if (int'(iopl) >= int'(cpl))         nf = nf & ~(1 << 7);
          else if (cpl == 3 && pvi == 1)       nf = nf & ~(1 << 8);
          else                                 m_gp = 1;
        end else begin
          m_tag = "R8";
          if (iopl == 3)                       nf = nf & ~(1 << 7);
          else if (vme == 1)                   nf = nf & ~(1 << 8);
          else                                 m_gp = 1;
        end
      end
      if (load_en) begin nf = int'(load_flags); m_tag = "R10"; end
      m_flags = nf;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      total++;
      if (flags_q !== 9'(m_flags)) begin
        bad++;
        $display("FAIL %s flags actual=%h expected=%h", m_tag, flags_q, 9'(m_flags));
      end
      total++;
      if (gp_fault !== m_gp || ud_fault !== m_ud) begin
        bad++;
        $display("FAIL %s/R9 faults actual gp=%b ud=%b expected gp=%b ud=%b",
                 m_tag, gp_fault, ud_fault, m_gp, m_ud);
      end
    end
  end

  task automatic idle();
    op_valid = 0; load_en = 0; lock_pfx = 0;
    @(negedge clk);
  endtask

  task automatic preload(input logic [8:0] v);
    op_valid = 0; load_en = 1; load_flags = v;
    @(negedge clk);
    load_en = 0;
  endtask

  task automatic issue(input logic [7:0] opc, input logic lk,
                       input logic [3:0] md, input logic [1:0] c, input logic [1:0] io);
    {pe, vm, vme, pvi} = md;
    cpl = c; iopl = io;
    opcode = opc; lock_pfx = lk; op_valid = 1; load_en = 0;
    @(negedge clk);
    op_valid = 0; lock_pfx = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);   // R1 reset state checked each cycle
    rst = 0;
    idle();
    // R2 / R3 from all ones
    preload(9'h1FF); issue(8'hF8, 0, 4'b0000, 0, 0); idle();
    issue(8'hFC, 0, 4'b0000, 0, 0); idle();
    // R4 lock on each supported opcode, then back-to-back
    preload(9'h1FF);
    issue(8'hF8, 1, 4'b0000, 0, 0);
    issue(8'hFC, 1, 4'b0000, 0, 0);
    issue(8'hFA, 1, 4'b1000, 3, 0);   // would GP, lock gives UD only
    idle();
    // R5 unsupported opcodes with and without lock
    issue(8'h90, 0, 4'b0000, 0, 0);
    issue(8'hFB, 1, 4'b0000, 0, 0);
    issue(8'hF9, 0, 4'b1100, 3, 0);
    idle();
    // R6, R7, R8: exhaustive over mode bits and levels
    for (int k = 0; k < 256; k++) begin
      preload(9'h1FF);
      issue(8'hFA, 0, 4'(k >> 4), 2'(k >> 2), 2'(k));
    end
    idle();
    // R9 consecutive faults
    preload(9'h0AA);
    issue(8'hFA, 0, 4'b1000, 2, 1);
    issue(8'hFA, 0, 4'b1100, 0, 1);
    issue(8'hF8, 1, 4'b0000, 0, 0);
    idle();
    // R10 load in the same cycle as an instruction that would clear
    {pe, vm, vme, pvi} = 4'b0000;
    opcode = 8'hF8; op_valid = 1; load_en = 1; load_flags = 9'h155;
    @(negedge clk);
    opcode = 8'hFA; {pe, vm, vme, pvi} = 4'b1100; iopl = 0;   // GP plus load
    load_flags = 9'h0FF;
    @(negedge clk);
    op_valid = 0; load_en = 0;
    idle(); idle();
    // R1 reset mid-run
    preload(9'h1FF);
    rst = 1; @(negedge clk); @(negedge clk);
    rst = 0; idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule